// File: doc/BRIEF.md
# Absolute-to-Physical Address Mapper

This block turns a 64-bit absolute address into a physical address. It is used on the path where virtual translation is switched off. Two mode inputs select how the address is reduced to the implemented physical width `PA_W`:

- **Wide mode** keeps the low `PA_W` bits.
- **Legacy 32-bit mode** keeps the low word and zero-extends it.
- **Narrow mode** reads address bits 31:24 and chooses one of three regions, each widened in its own way:
  - a memory region, zero-extended;
  - an I/O region, sign-extended;
  - a firmware region, zero-extended with the four top physical bits forced high.

Every untranslated access is granted read, write and execute permission.

The mapping itself is combinational. By default (`REG_OUT` = 1) a one-entry hold stage sits at the output and moves results with a valid/ready handshake at full throughput.

The hold stage has two states, `ST_EMPTY` and `ST_FULL`, with these transitions:

| Transition | From → To | Condition |
|---|---|---|
| fill | `ST_EMPTY` → `ST_FULL` | an input is accepted |
| stall | `ST_FULL` → `ST_FULL` | the consumer is not ready |
| refill | `ST_FULL` → `ST_FULL` | the old result drains and a new input is accepted in the same cycle |
| drain | `ST_FULL` → `ST_EMPTY` | the result leaves and no new input arrives |

Setting `REG_OUT` to 0 replaces the stage with wires. The permitted range of `PA_W` (36 to 54) is checked during elaboration.

Top module: `abs_phys_mapper`

## Requirements
- R1: With `in_wide`=1, `out_phys` equals `in_addr[PA_W-1:0]`, whatever `in_legacy` is.
- R2: With `in_wide`=0, `in_legacy`=0 and `in_addr[31:28]` != 4'hF (memory region), `out_phys` is `in_addr[31:0]` zero-extended to `PA_W` bits.
- R3: With `in_wide`=0, `in_legacy`=0, `in_addr[31:28]`=4'hF and `in_addr[27:24]` != 0 (I/O region), `out_phys` is `in_addr[31:0]` sign-extended to `PA_W` bits.
- R4: With `in_wide`=0, `in_legacy`=0, `in_addr[31:28]`=4'hF and `in_addr[27:24]`=0 (firmware region), `out_phys` is `in_addr[31:0]` zero-extended, with `out_phys[PA_W-1:PA_W-4]` set to 4'hF.
- R5: With `in_wide`=0 and `in_legacy`=1, `out_phys` is `in_addr[31:0]` zero-extended, in every region.
- R6: With `in_wide`=0, bits 63:32 of `in_addr` have no effect on `out_phys`.
- R7: Every result carries `out_perm` = 3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_phys` stays unchanged. Results leave in the order the inputs were accepted, exactly one result per accepted input.
- R10: While `out_ready`=1, `in_ready` is 1, so a full stage drains and refills in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input address is valid |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 64 | Absolute address |
| in_wide | input | 1 | Wide-address mode |
| in_legacy | input | 1 | Legacy 32-bit architecture mode |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_phys | output | PA_W | Physical address |
| out_perm | output | 3 | Granted permissions {read, write, execute} |

## Verification
Two functions of the hold stage can fall in the same cycle: draining a held result and loading the next mapped address (the refill transition). The bench provokes this by driving `in_valid` and `out_ready` high together while the stage is full, both in randomized traffic and in back-to-back directed sends.

It judges the outcome by checking that `in_ready` stays high in that cycle. Each result must also match the oldest expected value in a bench queue, so a refill that drops, duplicates or reorders an address shows up as a value mismatch.

// File: rtl/absmap_pkg.sv
package absmap_pkg;

    // Which reduction applies to an incoming absolute address.
    typedef enum logic [1:0] {
        MAP_WIDE   = 2'd0,
        MAP_LEGACY = 2'd1,
        MAP_NARROW = 2'd2
    } map_mode_e;

    // Narrow-mode region classes, one-hot so a checker can test exclusivity.
    typedef enum logic [2:0] {
        RGN_MEM = 3'b001,
        RGN_IO  = 3'b010,
        RGN_FW  = 3'b100
    } region_e;

    localparam int unsigned ABS_W    = 64;
    localparam int unsigned LOW_W    = 32;
    localparam int unsigned PERM_W   = 3;
    localparam int unsigned PA_W_MAX = 54;
    localparam int unsigned PA_W_MIN = 36;

endpackage

// File: rtl/absmap_mode_sel.sv
module absmap_mode_sel
    import absmap_pkg::*;
(
    input  logic      wide,
    input  logic      legacy,
    output map_mode_e mode
);

    // Wide mode has priority; legacy applies only when wide is off.
    always_comb begin
        if (wide) begin
            mode = MAP_WIDE;
        end else if (legacy) begin
            mode = MAP_LEGACY;
        end else begin
            mode = MAP_NARROW;
        end
    end

endmodule

// File: rtl/absmap_region_dec.sv
module absmap_region_dec
    import absmap_pkg::*;
(
    input  logic [7:0] top_byte,   // absolute address bits 31:24
    output region_e    region
);

    logic [3:0] hi_nib;
    logic [3:0] lo_nib;

    assign hi_nib = top_byte[7:4];
    assign lo_nib = top_byte[3:0];

    always_comb begin
        if (hi_nib != 4'hF) begin
            region = RGN_MEM;
        end else if (lo_nib != 4'h0) begin
            region = RGN_IO;
        end else begin
            region = RGN_FW;
        end
    end

endmodule

// File: rtl/absmap_extend.sv
module absmap_extend
    import absmap_pkg::*;
#(
    parameter int unsigned PA_W = 40
) (
    input  map_mode_e         mode,
    input  region_e           region,
    input  logic [PA_W-1:0]   addr_lo,
    output logic [PA_W-1:0]   phys
);

    localparam int unsigned PAD_W = PA_W - LOW_W;
    localparam logic [PA_W-1:0] TOP_NIB_MASK = {4'hF, {(PA_W-4){1'b0}}};

    logic [LOW_W-1:0] word;
    logic [PA_W-1:0]  zext;
    logic [PA_W-1:0]  sext;
    logic [PA_W-1:0]  fw_map;

    assign word   = addr_lo[LOW_W-1:0];
    assign zext   = {{PAD_W{1'b0}}, word};
    assign sext   = {{PAD_W{word[LOW_W-1]}}, word};
    assign fw_map = zext | TOP_NIB_MASK;

    always_comb begin
        phys = zext;
        unique case (mode)
            MAP_WIDE:   phys = addr_lo;
            MAP_LEGACY: phys = zext;
            MAP_NARROW: begin
                unique case (region)
                    RGN_MEM: phys = zext;
                    RGN_IO:  phys = sext;
                    RGN_FW:  phys = fw_map;
                    default: phys = zext;
                endcase
            end
            default:    phys = zext;
        endcase
    end

endmodule

// File: rtl/absmap_hold_stage.sv
module absmap_hold_stage #(
    parameter int unsigned W = 43
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

    hold_state_e  state_q;
    hold_state_e  state_d;
    logic [W-1:0] data_q;
    logic         load;

    // Next-state selection: fill, stall, refill, drain.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode for the current state.
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
        endcase
    end

    assign load     = in_valid && in_ready;
    assign out_data = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= in_data;
        end
    end

    // R9: a stalled result neither disappears nor changes.
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: a draining consumer always lets the next input in.
    a_r10_ready_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    // R8: an empty stage is always ready.
    a_r8_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
    import absmap_pkg::*;
#(
    parameter int unsigned PA_W    = 40,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      in_addr,
    input  logic             in_wide,
    input  logic             in_legacy,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PA_W-1:0]  out_phys,
    output logic [2:0]       out_perm
);

    localparam int unsigned PKT_W = PA_W + PERM_W;
    localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

    // Bounds on the physical width, enforced at elaboration.
    if (PA_W > PA_W_MAX || PA_W < PA_W_MIN) begin : g_pa_w_bad
        $error("abs_phys_mapper: PA_W outside 36..54");
    end

    map_mode_e        mode;
    region_e          region;
    logic [PA_W-1:0]  mapped;
    logic [PKT_W-1:0] pkt_in;
    logic [PKT_W-1:0] pkt_out;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^in_addr[ABS_W-1:PA_W];

    absmap_mode_sel u_mode (
        .wide   (in_wide),
        .legacy (in_legacy),
        .mode   (mode)
    );

    absmap_region_dec u_dec (
        .top_byte (in_addr[31:24]),
        .region   (region)
    );

    absmap_extend #(.PA_W(PA_W)) u_ext (
        .mode    (mode),
        .region  (region),
        .addr_lo (in_addr[PA_W-1:0]),
        .phys    (mapped)
    );

    assign pkt_in = {PERM_ALL, mapped};

    if (REG_OUT) begin : g_reg
        absmap_hold_stage #(.W(PKT_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (pkt_in),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (pkt_out)
        );
    end else begin : g_wire
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign pkt_out   = pkt_in;
    end

    assign out_phys = pkt_out[PA_W-1:0];
    assign out_perm = pkt_out[PKT_W-1:PA_W];

    // R2 R3 R4: the narrow decoder yields exactly one region.
    a_r2_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_legacy) |-> $onehot(region));

    // R6: outside wide mode the low word passes through untouched.
    a_r6_low_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |-> (mapped[31:0] == in_addr[31:0]));

    // R1: wide mode overrides the legacy selection.
    a_r1_wide_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide) |-> (mapped == in_addr[PA_W-1:0]));

endmodule

// File: tb/abs_phys_mapper_test.sv
module abs_phys_mapper_test;

    localparam int unsigned PA_W = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [63:0]     in_addr = '0;
    logic            in_wide = 1'b0;
    logic            in_legacy = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [PA_W-1:0] out_phys;
    logic [2:0]      out_perm;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned cycles  = 0;
    bit          finished = 1'b0;

    logic [PA_W-1:0] exp_q[$];
    string           tag_q[$];
    bit              prev_stall = 1'b0;
    logic [PA_W-1:0] prev_phys = '0;

    always #10 clk = ~clk;   // 50 MHz

    abs_phys_mapper #(.PA_W(PA_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_wide   (in_wide),
        .in_legacy (in_legacy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_phys  (out_phys),
        .out_perm  (out_perm)
    );

    function automatic logic [PA_W-1:0] ref_map(logic [63:0] a, logic w, logic l);
        logic [PA_W-1:0] z;
        z = {{(PA_W-32){1'b0}}, a[31:0]};
        if (w) return a[PA_W-1:0];
        if (l) return z;
        if (a[31:28] != 4'hF) return z;
        if (a[27:24] != 4'h0) return {{(PA_W-32){1'b1}}, a[31:0]};
        return {4'hF, z[PA_W-5:0]};
    endfunction

    function automatic string ref_tag(logic [63:0] a, logic w, logic l);
        if (w) return "R1";
        if (l) return "R5";
        if (a[31:28] != 4'hF) return "R2";
        if (a[27:24] != 4'h0) return "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns later, before the rising edge.
    task automatic step(logic v, logic [63:0] a, logic w, logic l, logic r);
        @(negedge clk);
        in_valid = v; in_addr = a; in_wide = w; in_legacy = l; out_ready = r;
        #1;
        if (prev_stall) begin
            check("R9 stalled valid", 64'(out_valid), 64'd1);
            check("R9 stalled value", 64'(out_phys), 64'(prev_phys));
        end
        if (out_ready) check("R10 ready on drain", 64'(in_ready), 64'd1);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R9 spurious result", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), 64'(out_phys), 64'(exp_q.pop_front()));
                check("R7 perm", 64'(out_perm), 64'h7);
            end
        end
        if (in_valid && in_ready) begin
            exp_q.push_back(ref_map(a, w, l));
            tag_q.push_back(ref_tag(a, w, l));
        end
        prev_stall = out_valid && !out_ready;
        prev_phys  = out_phys;
    endtask

    task automatic send(logic [63:0] a, logic w, logic l);
        bit took;
        took = 1'b0;
        while (!took) begin
            step(1'b1, a, w, l, 1'b1);
            took = in_ready;
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        check("R9 all results delivered", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 out_valid after reset", 64'(out_valid), 64'd0);
        check("R8 in_ready after reset", 64'(in_ready), 64'd1);

        // Directed corner cases.
        send(64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0);   // memory
        send(64'h0000_0000_EFFF_FFFF, 1'b0, 1'b0);   // memory, nibble boundary
        send(64'h0000_0000_F100_0000, 1'b0, 1'b0);   // I/O lowest
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);   // I/O highest
        send(64'h0000_0000_F000_0000, 1'b0, 1'b0);   // firmware lowest
        send(64'h1234_0000_F0FF_FFFF, 1'b0, 1'b0);   // firmware highest, R6 upper junk
        send(64'hFFFF_FFFF_F0FF_FFFF, 1'b0, 1'b1);   // legacy in firmware range
        send(64'h0000_0000_F800_0001, 1'b0, 1'b1);   // legacy in I/O range
        send(64'hA5A5_A5FF_F000_0000, 1'b1, 1'b0);   // wide
        send(64'h0000_00FF_F000_0000, 1'b1, 1'b1);   // wide wins over legacy
        drain();

        // R6: identical low words with different upper halves map the same.
        send(64'h0000_0000_F300_0042, 1'b0, 1'b0);
        send(64'h7777_0000_F300_0042, 1'b0, 1'b0);
        drain();

        // R9/R10: stall with a queued result, then refill while draining.
        step(1'b1, 64'h0000_0000_1000_0000, 1'b0, 1'b0, 1'b0);
        step(1'b1, 64'h0000_0000_2000_0000, 1'b0, 1'b0, 1'b0);
        step(1'b1, 64'h0000_0000_2000_0000, 1'b0, 1'b0, 1'b0);
        step(1'b1, 64'h0000_0000_2000_0000, 1'b0, 1'b0, 1'b1);
        step(1'b1, 64'h0000_0000_F000_1111, 1'b0, 1'b0, 1'b1);
        drain();

        // Constrained random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] a;
            logic [2:0]  sel;
            a   = {$urandom(), $urandom()};
            sel = 3'($urandom() % 8);
            if (sel < 3) a[31:28] = 4'hF;
            if (sel == 0) a[27:24] = 4'h0;
            step(($urandom() % 10) < 7, a,
                 ($urandom() % 4) == 0, ($urandom() % 4) == 0,
                 ($urandom() % 10) < 6);
        end
        drain();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule